// File: doc/BRIEF.md
# Strided span DMA controller

This block moves data in 8-byte beats between a 64-bit external DRAM port and a small on-chip local memory made of two 4 KB banks, a data bank and an instruction bank. Software loads a staging local address and a staging DRAM address, then writes a packed length word. The length word describes a rectangle: a number of spans, each of the same byte length, with a fixed gap skipped on the DRAM side between one span and the next. The local side stays contiguous.

Which length register receives the word sets the direction: one starts a DRAM-to-local copy, the other a local-to-DRAM copy. The engine holds one active transfer and one queued request. A request written while the engine is busy waits in the queue and is started as soon as the active transfer ends. A request written while the queue is occupied is dropped. Status shows whether the engine is busy and whether the queue is occupied. A one-cycle done pulse marks the end of each transfer.

Top module: `span_dma`

## Requirements
- R1: While rst_ni is low and right after it rises, busy_o, full_o, done_o, dram_req_o, dram_we_o and lmem_we_o are all 0.
- R2: Register 0 holds a 13-bit local address (bit 12 selects the bank, 1 = instruction bank; bits 11:0 are the byte offset). Register 1 holds a 24-bit DRAM byte address. Both read back as written, zero-extended, with the upper write bits discarded.
- R3: In a length word, bits 11:0 are bytes per span minus one, bits 19:12 are spans minus one, and bits 31:20 are the DRAM skip in bytes. The low three bits of every address, length and skip value are ignored, so a span carries length[11:3]+1 beats.
- R4: Writing register 2 starts a DRAM-to-local transfer. dram_we_o stays 0, and on each acknowledged beat lmem_we_o is 1 and lmem_wdata_o equals dram_rdata_i.
- R5: Writing register 3 starts a local-to-DRAM transfer. dram_we_o is 1 while it runs, and dram_wdata_o equals lmem_rdata_i.
- R6: The DRAM address rises by 8 per beat within a span. The first beat of the next span sits at the previous span's last beat address plus 8 plus the skip. The address wraps at 24 bits.
- R7: The local beat address (lmem_addr_o = byte offset / 8) rises by one per beat across all spans, with no skip. It wraps inside the selected bank, and lmem_bank_o keeps the bank bit for the whole transfer.
- R8: A beat completes only in a cycle with dram_req_o and dram_ack_i both 1. Otherwise both addresses hold. dram_req_o is 1 exactly while busy.
- R9: busy_o rises one cycle after a start write to an idle engine. full_o rises one cycle after a start write made while busy and not finishing. Register 4 reads {full, busy} in bits 1:0, register 5 bit 0 reads full, and register 6 bit 0 reads busy.
- R10: A start write made while full_o is 1 is dropped, even in the cycle where the active transfer ends.
- R11: When the active transfer ends with a queued request, that request starts on the next cycle and busy_o stays 1.
- R12: done_o is 1 for one cycle, the cycle after the final beat of the last span is acknowledged. busy_o falls at that same edge unless a queued request exists, or a start write arrives in the final-beat cycle while the queue is empty; in either of those cases the new transfer starts without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| dram_req_o | output | 1 | DRAM beat request |
| dram_we_o | output | 1 | DRAM beat is a write |
| dram_addr_o | output | 24 | DRAM byte address of the beat |
| dram_wdata_o | output | 64 | DRAM write data |
| dram_ack_i | input | 1 | Beat accepted this cycle |
| dram_rdata_i | input | 64 | DRAM read data, valid with ack |
| lmem_we_o | output | 1 | Local memory write enable |
| lmem_bank_o | output | 1 | Bank select, 1 = instruction bank |
| lmem_addr_o | output | 9 | Local beat address within the bank |
| lmem_wdata_o | output | 64 | Local memory write data |
| lmem_rdata_i | input | 64 | Local memory read data, same-cycle |
| busy_o | output | 1 | Transfer active |
| full_o | output | 1 | Request queued |
| done_o | output | 1 | Transfer finished pulse |

## Verification
The critical coincidence is a start write landing in the same cycle as the final acknowledged beat. With the queue empty, the new request must start at once. With the queue occupied, the queued request is promoted and the new write is dropped. The bench provokes both cases with DRAM acknowledge held high and one- or two-beat transfers, and it places the writes exactly in the finishing cycle. A behavioural model tracks busy, full, done and both address streams on every clock, and the counts of done pulses and busy falling edges are checked afterwards.

// File: rtl/span_dma_pkg.sv
package span_dma_pkg;
  localparam int DADDR_W = 24;
  localparam int BANK_AW = 12;
  localparam int LEN_W   = 12;
  localparam int CNT_W   = 8;
  localparam int SKIP_W  = 12;
  localparam int BEAT_LG = 3;
  localparam int BEAT_W  = 64;
  localparam int REG_W   = 32;
  localparam int REG_AW  = 3;

  localparam int LADDR_W  = BANK_AW + 1;
  localparam int DWORD_W  = DADDR_W - BEAT_LG;
  localparam int LWORD_W  = BANK_AW - BEAT_LG;
  localparam int LENB_W   = LEN_W - BEAT_LG;
  localparam int SKIPB_W  = SKIP_W - BEAT_LG;
  localparam int CNT_LSB  = LEN_W;
  localparam int SKIP_LSB = LEN_W + CNT_W;

  typedef enum logic [REG_AW-1:0] {
    RA_LOCAL = 3'd0,
    RA_DRAM  = 3'd1,
    RA_RDLEN = 3'd2,
    RA_WRLEN = 3'd3,
    RA_STAT  = 3'd4,
    RA_FULL  = 3'd5,
    RA_BUSY  = 3'd6,
    RA_RSVD  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic               to_local;
    logic               bank;
    logic [LWORD_W-1:0] lword;
    logic [DWORD_W-1:0] dword;
    logic [LENB_W-1:0]  beats_m1;
    logic [CNT_W-1:0]   spans_m1;
    logic [SKIPB_W-1:0] skip_w;
  } xfer_t;
endpackage

// File: rtl/span_dma_regs.sv
module span_dma_regs
  import span_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              busy_i,
  input  logic              full_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              req_valid_o,
  output xfer_t             req_o
);
  logic [LADDR_W-1:0] laddr_q;
  logic [DADDR_W-1:0] daddr_q;
  reg_addr_e          ra;

  assign ra = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      laddr_q <= '0;
      daddr_q <= '0;
    end else if (we_i) begin
      case (ra)
        RA_LOCAL: laddr_q <= wdata_i[LADDR_W-1:0];
        RA_DRAM:  daddr_q <= wdata_i[DADDR_W-1:0];
        default: ;
      endcase
    end
  end

  assign req_valid_o = we_i && (ra == RA_RDLEN || ra == RA_WRLEN);

  always_comb begin
    req_o.to_local = (ra == RA_RDLEN);
    req_o.bank     = laddr_q[BANK_AW];
    req_o.lword    = laddr_q[BANK_AW-1:BEAT_LG];
    req_o.dword    = daddr_q[DADDR_W-1:BEAT_LG];
    req_o.beats_m1 = wdata_i[LEN_W-1:BEAT_LG];
    req_o.spans_m1 = wdata_i[CNT_LSB +: CNT_W];
    req_o.skip_w   = wdata_i[SKIP_LSB+BEAT_LG +: SKIPB_W];
  end

  always_comb begin
    case (ra)
      RA_LOCAL: rdata_o = REG_W'(laddr_q);
      RA_DRAM:  rdata_o = REG_W'(daddr_q);
      RA_STAT:  rdata_o = REG_W'({full_i, busy_i});
      RA_FULL:  rdata_o = REG_W'(full_i);
      RA_BUSY:  rdata_o = REG_W'(busy_i);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/span_dma_slot.sv
module span_dma_slot
  import span_dma_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_valid_i,
  input  xfer_t req_i,
  input  logic  busy_i,
  input  logic  finish_i,
  output logic  launch_o,
  output xfer_t launch_xfer_o,
  output logic  full_o
);
  logic  full_q;
  xfer_t pend_q;
  logic  promote, take_now, park;

  assign promote  = finish_i & full_q;
  // direct start when idle, or when the active one ends with nothing queued
  assign take_now = req_valid_i & (~busy_i | (finish_i & ~full_q));
  assign park     = req_valid_i & busy_i & ~finish_i & ~full_q;

  assign launch_o      = promote | take_now;
  assign launch_xfer_o = promote ? pend_q : req_i;
  assign full_o        = full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      pend_q <= '0;
    end else if (promote) begin
      full_q <= 1'b0;
    end else if (park) begin
      full_q <= 1'b1;
      pend_q <= req_i;
    end
  end
endmodule

// File: rtl/span_dma_engine.sv
module span_dma_engine
  import span_dma_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  xfer_t              xfer_i,
  input  logic               dram_ack_i,
  output logic               dram_req_o,
  output logic               dram_we_o,
  output logic [DADDR_W-1:0] dram_addr_o,
  output logic               lmem_we_o,
  output logic               lmem_bank_o,
  output logic [LWORD_W-1:0] lmem_addr_o,
  output logic               busy_o,
  output logic               finish_o,
  output logic               done_o
);
  logic               busy_q, done_q, to_local_q, bank_q;
  logic [LWORD_W-1:0] lw_q;
  logic [DWORD_W-1:0] dw_q;
  logic [LENB_W-1:0]  beat_q, beats_m1_q;
  logic [CNT_W-1:0]   span_q, spans_m1_q;
  logic [SKIPB_W-1:0] skip_q;
  logic               fire, last_beat, last_span, finish;

  assign fire      = busy_q & dram_ack_i;
  assign last_beat = (beat_q == beats_m1_q);
  assign last_span = (span_q == spans_m1_q);
  assign finish    = fire & last_beat & last_span;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      to_local_q <= 1'b0;
      bank_q     <= 1'b0;
      lw_q       <= '0;
      dw_q       <= '0;
      beat_q     <= '0;
      beats_m1_q <= '0;
      span_q     <= '0;
      spans_m1_q <= '0;
      skip_q     <= '0;
    end else begin
      done_q <= finish;
      if (launch_i) begin
        busy_q     <= 1'b1;
        to_local_q <= xfer_i.to_local;
        bank_q     <= xfer_i.bank;
        lw_q       <= xfer_i.lword;
        dw_q       <= xfer_i.dword;
        beats_m1_q <= xfer_i.beats_m1;
        spans_m1_q <= xfer_i.spans_m1;
        skip_q     <= xfer_i.skip_w;
        beat_q     <= '0;
        span_q     <= '0;
      end else if (fire) begin
        lw_q <= lw_q + LWORD_W'(1);
        if (last_beat) begin
          beat_q <= '0;
          span_q <= span_q + CNT_W'(1);
          dw_q   <= dw_q + DWORD_W'(1) + DWORD_W'(skip_q);
        end else begin
          beat_q <= beat_q + LENB_W'(1);
          dw_q   <= dw_q + DWORD_W'(1);
        end
        if (finish) busy_q <= 1'b0;
      end
    end
  end

  assign dram_req_o  = busy_q;
  assign dram_we_o   = busy_q & ~to_local_q;
  assign dram_addr_o = {dw_q, {BEAT_LG{1'b0}}};
  assign lmem_we_o   = fire & to_local_q;
  assign lmem_bank_o = bank_q;
  assign lmem_addr_o = lw_q;
  assign busy_o      = busy_q;
  assign finish_o    = finish;
  assign done_o      = done_q;
endmodule

// File: rtl/span_dma.sv
module span_dma
  import span_dma_pkg::*;
#(
  parameter int DATA_W = BEAT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               dram_req_o,
  output logic               dram_we_o,
  output logic [DADDR_W-1:0] dram_addr_o,
  output logic [DATA_W-1:0]  dram_wdata_o,
  input  logic               dram_ack_i,
  input  logic [DATA_W-1:0]  dram_rdata_i,
  output logic               lmem_we_o,
  output logic               lmem_bank_o,
  output logic [LWORD_W-1:0] lmem_addr_o,
  output logic [DATA_W-1:0]  lmem_wdata_o,
  input  logic [DATA_W-1:0]  lmem_rdata_i,
  output logic               busy_o,
  output logic               full_o,
  output logic               done_o
);
  logic  req_valid, launch, finish, busy, full;
  xfer_t req, launch_xfer;

  span_dma_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .busy_i     (busy),
    .full_i     (full),
    .rdata_o    (reg_rdata_o),
    .req_valid_o(req_valid),
    .req_o      (req)
  );

  span_dma_slot u_slot (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid),
    .req_i        (req),
    .busy_i       (busy),
    .finish_i     (finish),
    .launch_o     (launch),
    .launch_xfer_o(launch_xfer),
    .full_o       (full)
  );

  span_dma_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .xfer_i     (launch_xfer),
    .dram_ack_i (dram_ack_i),
    .dram_req_o (dram_req_o),
    .dram_we_o  (dram_we_o),
    .dram_addr_o(dram_addr_o),
    .lmem_we_o  (lmem_we_o),
    .lmem_bank_o(lmem_bank_o),
    .lmem_addr_o(lmem_addr_o),
    .busy_o     (busy),
    .finish_o   (finish),
    .done_o     (done_o)
  );

  assign dram_wdata_o = lmem_rdata_i;
  assign lmem_wdata_o = dram_rdata_i;
  assign busy_o       = busy;
  assign full_o       = full;
endmodule

// File: rtl/span_dma_chk.sv
module span_dma_chk
  import span_dma_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               dram_ack_i,
  input logic               dram_req_o,
  input logic               dram_we_o,
  input logic [DADDR_W-1:0] dram_addr_o,
  input logic               lmem_we_o,
  input logic               lmem_bank_o,
  input logic [LWORD_W-1:0] lmem_addr_o,
  input logic               busy_o,
  input logic               full_o,
  input logic               done_o
);
  p_full_needs_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> busy_o);

  p_lwe_on_read_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lmem_we_o |-> (dram_ack_i && dram_req_o && !dram_we_o));

  p_hold_without_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dram_req_o && !dram_ack_i) |=>
      ($stable(dram_addr_o) && $stable(lmem_addr_o) && $stable(lmem_bank_o)));

  p_done_after_ack_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(dram_ack_i) && $past(dram_req_o)));

  p_local_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lmem_we_o) && busy_o && !done_o) |->
      (lmem_addr_o == LWORD_W'($past(lmem_addr_o) + LWORD_W'(1))));
endmodule

bind span_dma span_dma_chk u_chk (.*);

// File: tb/tb_span_dma.sv
module tb_span_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = 3'd4;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        dram_req_o, dram_we_o, dram_ack_i = 1'b0;
  logic [23:0] dram_addr_o;
  logic [63:0] dram_wdata_o, dram_rdata_i = '0, lmem_wdata_o, lmem_rdata_i = '0;
  logic        lmem_we_o, lmem_bank_o;
  logic [8:0]  lmem_addr_o;
  logic        busy_o, full_o, done_o;

  always #10 clk = ~clk;

  span_dma dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .dram_req_o(dram_req_o), .dram_we_o(dram_we_o), .dram_addr_o(dram_addr_o),
    .dram_wdata_o(dram_wdata_o), .dram_ack_i(dram_ack_i), .dram_rdata_i(dram_rdata_i),
    .lmem_we_o(lmem_we_o), .lmem_bank_o(lmem_bank_o), .lmem_addr_o(lmem_addr_o),
    .lmem_wdata_o(lmem_wdata_o), .lmem_rdata_i(lmem_rdata_i),
    .busy_o(busy_o), .full_o(full_o), .done_o(done_o)
  );

  int total = 0, bad = 0, cyc = 0;
  int n_lwe = 0, n_wbeat = 0, n_done = 0, n_fall = 0;
  bit prev_busy = 0;
  bit ack_always = 1;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  typedef struct {
    bit tol; int bank; int lb; int db; int beats; int spans; int skip;
  } mreq_t;
  mreq_t cur, nr;
  mreq_t pq[$];
  bit m_busy = 0, m_done = 0;
  int beat = 0, span = 0, st_l = 0, st_d = 0;
  bit fire, fin, newr;

  function automatic mreq_t mk(input int a, input logic [31:0] w);
    mreq_t r;
    r.tol   = (a == 2);
    r.bank  = (st_l >> 12) & 1;
    r.lb    = st_l & 'hFF8;
    r.db    = st_d & 'hFFFFF8;
    r.beats = int'((w >> 3) & 32'd511) + 1;
    r.spans = int'((w >> 12) & 32'd255) + 1;
    r.skip  = int'((w >> 23) & 32'd511) * 8;
    return r;
  endfunction

  task automatic load(input mreq_t r);
    cur = r; beat = 0; span = 0; m_busy = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; pq.delete(); st_l = 0; st_d = 0;
    end else begin
      fire = m_busy && dram_ack_i;
      fin  = fire && (beat == cur.beats - 1) && (span == cur.spans - 1);
      newr = reg_we_i && (reg_addr_i == 3'd2 || reg_addr_i == 3'd3);
      if (newr) nr = mk(int'(reg_addr_i), reg_wdata_i);
      m_done = fin;
      if (fire && !fin) begin
        cur.lb = (cur.lb + 8) & 'hFFF;
        if (beat == cur.beats - 1) begin
          beat = 0; span++;
          cur.db = (cur.db + 8 + cur.skip) & 'hFFFFFF;
        end else begin
          beat++;
          cur.db = (cur.db + 8) & 'hFFFFFF;
        end
      end
      if (fin) begin
        if (pq.size() > 0) load(pq.pop_front());
        else if (newr) load(nr);
        else m_busy = 0;
      end else if (newr) begin
        if (!m_busy) load(nr);
        else if (pq.size() == 0) pq.push_back(nr);
      end
      if (reg_we_i && reg_addr_i == 3'd0) st_l = int'(reg_wdata_i & 32'h1FFF);
      if (reg_we_i && reg_addr_i == 3'd1) st_d = int'(reg_wdata_i & 32'hFFFFFF);
    end
  end

  // DRAM and local memory stimulus
  always @(negedge clk) begin
    dram_ack_i   <= ack_always ? 1'b1 : ($urandom % 3 != 0);
    dram_rdata_i <= {$urandom, $urandom};
    lmem_rdata_i <= {$urandom, $urandom};
  end

  // per-cycle comparison against the model
  always begin
    @(negedge clk);
    #8;
    if (rst_n) begin
      longint rb;
      bit mfull;
      mfull = (pq.size() != 0);
      chk("R9 busy", busy_o, m_busy);
      chk("R9 full", full_o, mfull);
      chk("R12 done", done_o, m_done);
      chk("R8 req", dram_req_o, m_busy);
      chk("R5 dram_we", dram_we_o, m_busy && !cur.tol);
      chk("R4 lmem_we", lmem_we_o, m_busy && cur.tol && dram_ack_i);
      if (m_busy) begin
        chk("R6 dram_addr", dram_addr_o, cur.db);
        chk("R7 lmem_addr", lmem_addr_o, cur.lb >> 3);
        chk("R7 bank", lmem_bank_o, cur.bank);
      end
      if (lmem_we_o) chk("R4 data", lmem_wdata_o, dram_rdata_i);
      if (dram_we_o) chk("R5 data", dram_wdata_o, lmem_rdata_i);
      case (reg_addr_i)
        3'd0: rb = st_l;
        3'd1: rb = st_d;
        3'd4: rb = {mfull, m_busy};
        3'd5: rb = mfull;
        3'd6: rb = m_busy;
        default: rb = 0;
      endcase
      chk("R2 R9 readback", reg_rdata_o, rb);
      if (lmem_we_o) n_lwe++;
      if (dram_we_o && dram_ack_i) n_wbeat++;
      if (done_o) n_done++;
      if (prev_busy && !busy_o) n_fall++;
      prev_busy = busy_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a[2:0]; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0; reg_addr_i = 3'd4;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy_o !== 1'b0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clr();
    n_lwe = 0; n_wbeat = 0; n_done = 0; n_fall = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 busy", busy_o, 0);
    chk("R1 full", full_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 req", dram_req_o, 0);
    chk("R1 lwe", lmem_we_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after", busy_o, 0);

    // R2: staging readback with discarded upper bits
    wr(0, 32'hFFFF_FFF7);
    wr(1, 32'h12AB_CDEF);
    reg_addr_i = 3'd0; @(negedge clk);
    chk("R2 local", reg_rdata_o, 32'h1FF7);
    reg_addr_i = 3'd1; @(negedge clk);
    chk("R2 dram", reg_rdata_o, 32'hABCDEF);

    // R4 R3 R6: DRAM to local, 3 spans of 3 beats, skip 16
    clr();
    wr(0, 32'h0010);
    wr(1, 32'h0001_00);
    wr(2, (32'd16 << 20) | (32'd2 << 12) | 32'h17);
    wait_idle();
    chk("R3 R4 beats", n_lwe, 9);
    chk("R12 done count", n_done, 1);

    // R5 R7 R3: local to DRAM, bank 1 wrap, DRAM wrap, ignored low bits
    ack_always = 0;
    clr();
    wr(0, 32'h1FF0);
    wr(1, 32'hFFFFC0);
    wr(3, (32'h105 << 20) | (32'd1 << 12) | 32'h1F);
    wait_idle();
    chk("R3 R5 beats", n_wbeat, 8);
    chk("R4 no lmem write", n_lwe, 0);

    // R10 R11: queue one, drop one
    clr();
    wr(0, 32'h0800);
    wr(1, 32'h2000);
    wr(3, (32'd1 << 12) | 32'h18);
    wr(0, 32'h1100);
    wr(2, 32'h0008);
    wr(2, 32'h0038);
    wait_idle();
    chk("R10 dropped", n_done, 2);
    chk("R11 no gap", n_fall, 1);
    chk("R10 R11 beats", n_lwe, 2);

    // R12: start write in the finishing cycle, queue empty
    ack_always = 1;
    @(negedge clk);
    clr();
    wr(3, 32'h0);
    wr(2, 32'h0);
    wait_idle();
    chk("R12 back to back", n_done, 2);
    chk("R12 busy falls once", n_fall, 1);

    // R10: write in the finishing cycle while full is dropped
    clr();
    wr(3, 32'h8);
    wr(2, 32'h0);
    wr(2, 32'h10);
    wait_idle();
    chk("R10 full at finish", n_done, 2);
    chk("R10 beats", n_lwe, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule